// File: doc/BRIEF.md
# High-Speed Serial Receive Path

This block receives 8N1 asynchronous serial characters on a single input line. The line is oversampled at 14 sub-samples per bit. The sub-sample rate comes from an 8-bit divisor, so one bit lasts `(divisor + 1) * 14` clocks. Each finished character goes into a 64-entry FIFO together with two tag bits: one marks a framing error and one marks a break. Software pops the FIFO through a small word-addressed register port, and every pop returns the data byte, an empty flag and the two tags in one word.

Two receive interrupt sources are offered. The first is a fill-level trigger with a selectable threshold. The second is an inactivity timeout, counted in character times, which fires when bytes sit in the FIFO and nothing arrives. Framing errors, breaks and overruns are held in sticky status bits that software clears by writing 1 to them. One interrupt line combines the receive sources and the error sources under two separate enable bits.

The receiver runs as a five-state machine:
- RX_IDLE waits on a sub-sample tick for the line to go low.
- RX_START validates the start bit at mid-bit. If the line is high there, a glitch has been seen and the machine goes back to RX_IDLE. Otherwise it moves on to RX_DATA at the end of the bit.
- RX_DATA shifts in eight bits, LSB first, each sampled at sub-sample 7 of 14, and then moves to RX_STOP.
- RX_STOP samples the stop bit at mid-bit and writes the entry. On a high stop bit it returns to RX_IDLE. On a low stop bit it goes to RX_HOLD.
- RX_HOLD waits until the line is high again, and only then returns to RX_IDLE.

Register word addresses on `reg_addr`:
- 0: FIFO pop
- 1: level
- 2: interrupt status
- 3: control
- 4: rate divisor

Top module: `hsrx_top`

## Requirements
- R1: After reset the rate register (address 4, bits 7:0) reads 0xFF. The control register (address 3), the level register (address 1) and the status register (address 2) read 0, and `irq` is low.
- R2: A character is framed as start bit, 8 data bits LSB first, then stop bit, and each bit lasts `(rate+1)*14` clocks. A character with a high stop bit is stored unchanged in bits 7:0 of the FIFO word, with bits 10:8 clear.
- R3: A low pulse on the line that is shorter than half a bit time is rejected when the start bit is checked at mid-bit. It adds no FIFO entry.
- R4: A low stop bit after nonzero data stores the byte with the framing tag set (FIFO word bit 9). It also sets the sticky framing bit, status bit 3.
- R5: A character that is all zeros, stop bit included, is stored as a break entry: data 0 and break tag set (FIFO word bit 10). It also sets the sticky break bit, status bit 4. While the line stays low afterwards, the receiver starts no new character.
- R6: The FIFO holds 64 entries and returns them in arrival order. Level register bits 7:0 give the current count.
- R7: A character that completes while the FIFO is full is discarded and sets the sticky overrun bit, status bit 5. The level stays at 64.
- R8: A read of address 0 while the FIFO is empty returns a word with bit 8 set and data 0. It leaves the FIFO contents and the level unchanged.
- R9: Control bits 4:2 select the trigger threshold: codes 0 to 5 give 1, 4, 8, 16, 32 and 48 entries, and codes 6 and 7 give 48. Status bit 1 reads 1 exactly while the level is at or above the threshold.
- R10: Control bits 17:16 select the inactivity timeout: 0 turns it off, and 1, 2 and 3 give 4, 8 and 16 character times, where one character time is 10 bit times. Status bit 2 sets when the FIFO is non-empty and no entry has been pushed or popped for that long. A push or a pop clears it.
- R11: Writing 1 to status bit 3, 4 or 5 clears that bit, and writing 0 leaves it unchanged. Writes to status bits 1 and 2 have no effect.
- R12: `irq` is high when control bit 6 is set and status bit 1 or 2 is set, or when control bit 7 is set and any of status bits 3 to 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 pops the FIFO |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt request |

## Verification
The line passes through a two-flop synchronizer and a registered push. A character therefore lands in the FIFO a few clocks after the middle of its stop bit, which is well before the serial task that sends it returns at the end of that stop bit. Register reads return on the clock after the strobe, and the bench samples `reg_rdata` at the falling edge that follows. The timeout is first checked about 100 clocks before it is due, at four character times after the push, and then about 200 clocks after it is due, so sub-sample phase cannot change either result. Sticky bits and `irq` are read only after the event that sets them has finished and settled.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic [7:0] data;
    } rx_entry_t;

    localparam logic [2:0] ADDR_FIFO  = 3'd0;
    localparam logic [2:0] ADDR_LEVEL = 3'd1;
    localparam logic [2:0] ADDR_STAT  = 3'd2;
    localparam logic [2:0] ADDR_CTRL  = 3'd3;
    localparam logic [2:0] ADDR_RATE  = 3'd4;

    // status bit positions
    localparam int ST_TRIG = 1;
    localparam int ST_TMO  = 2;
    localparam int ST_FE   = 3;
    localparam int ST_BRK  = 4;
    localparam int ST_OVR  = 5;

    // control bit positions
    localparam int CT_TRIG_LO = 2;
    localparam int CT_RX_IE   = 6;
    localparam int CT_ERR_IE  = 7;
    localparam int CT_TMO_LO  = 16;

    function automatic int trig_level(input logic [2:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

endpackage

// File: rtl/hsrx_baud.sv
module hsrx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hsrx_deser.sv
module hsrx_deser
    import hsrx_pkg::*;
#(
    parameter int OVS = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    output logic      push,
    output rx_entry_t entry
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS / 2 - 1);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

    rx_state_e      state, state_n;
    logic [SUB_W-1:0] sub, sub_n;
    logic [2:0]     bitn, bitn_n;
    logic [7:0]     sh, sh_n;
    logic           push_n;
    rx_entry_t      entry_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= '0;
        end else begin
            state <= state_n;
            sub   <= sub_n;
            bitn  <= bitn_n;
            sh    <= sh_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        sub_n   = sub;
        bitn_n  = bitn;
        sh_n    = sh;
        push_n  = 1'b0;
        entry_n = '0;
        unique case (state)
            RX_IDLE: begin
                if (tick && !rx) begin
                    state_n = RX_START;
                    sub_n   = SUB_W'(1);
                end
            end
            RX_START: begin
                if (tick) begin
                    if (sub == MID && rx) begin
                        state_n = RX_IDLE;
                        sub_n   = '0;
                    end else if (sub == LAST) begin
                        state_n = RX_DATA;
                        sub_n   = '0;
                        bitn_n  = '0;
                    end else begin
                        sub_n = sub + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (sub == MID)
                        sh_n = {rx, sh[7:1]};
                    if (sub == LAST) begin
                        sub_n = '0;
                        if (bitn == 3'd7)
                            state_n = RX_STOP;
                        else
                            bitn_n = bitn + 1'b1;
                    end else begin
                        sub_n = sub + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (sub == MID) begin
                        push_n       = 1'b1;
                        entry_n.data = sh;
                        entry_n.brk  = !rx && (sh == 8'h00);
                        entry_n.fe   = !rx && (sh != 8'h00);
                        state_n      = rx ? RX_IDLE : RX_HOLD;
                        sub_n        = '0;
                    end else begin
                        sub_n = sub + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (rx)
                    state_n = RX_IDLE;
            end
            default: state_n = RX_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push  <= 1'b0;
            entry <= '0;
        end else begin
            push  <= push_n;
            entry <= entry_n;
        end
    end
endmodule

// File: rtl/hsrx_fifo.sv
module hsrx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign count   = wptr - rptr;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/hsrx_idle.sv
module hsrx_idle #(
    parameter int CHAR_TICKS = 140,
    localparam int CNT_W     = $clog2(16 * CHAR_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clr,
    input  logic       active,
    input  logic [1:0] sel,
    output logic       expired
);
    logic [CNT_W-1:0] cnt, limit;

    always_comb begin
        unique case (sel)
            2'd1:    limit = CNT_W'(4 * CHAR_TICKS);
            2'd2:    limit = CNT_W'(8 * CHAR_TICKS);
            2'd3:    limit = CNT_W'(16 * CHAR_TICKS);
            default: limit = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (clr || !active || sel == 2'd0) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == limit - 1'b1)
                expired <= 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsrx_top.sv
module hsrx_top
    import hsrx_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int OVS       = 14,
    parameter int RATE_W    = 8,
    parameter int CHAR_BITS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_in,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CHAR_TICKS = OVS * CHAR_BITS;
    localparam int LVL_W      = $clog2(DEPTH) + 1;
    localparam int ENT_W      = $bits(rx_entry_t);

    logic [1:0]        rx_sync;
    logic              tick;
    logic              push;
    rx_entry_t         entry, head;
    logic [LVL_W-1:0]  lvl;
    logic              fifo_full, fifo_empty;
    logic              fifo_rd, pop_ok;
    logic              tmo_flag, trig_flag;
    logic              ovr_set;

    logic [RATE_W-1:0] rate_q;
    logic [2:0]        trig_sel;
    logic [1:0]        tmo_sel;
    logic              rx_ie, err_ie;
    logic              sts_ovr, sts_brk, sts_fe;
    logic              wr_stat;
    logic              unused_w;

    assign unused_w = ^{reg_wdata[31:18], reg_wdata[15:8], reg_wdata[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx_in};
    end

    hsrx_baud #(.DIV_W(RATE_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div(rate_q), .tick(tick)
    );

    hsrx_deser #(.OVS(OVS)) deser_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_sync[1]),
        .push(push), .entry(entry)
    );

    hsrx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(entry),
        .pop(fifo_rd), .rdata(head), .count(lvl),
        .full(fifo_full), .empty(fifo_empty)
    );

    hsrx_idle #(.CHAR_TICKS(CHAR_TICKS)) idle_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(push || pop_ok),
        .active(!fifo_empty), .sel(tmo_sel), .expired(tmo_flag)
    );

    assign fifo_rd   = reg_rd && (reg_addr == ADDR_FIFO);
    assign pop_ok    = fifo_rd && !fifo_empty;
    assign ovr_set   = push && fifo_full;
    assign trig_flag = int'(lvl) >= trig_level(trig_sel);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);

    // control and rate registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= '1;
            trig_sel <= '0;
            tmo_sel  <= '0;
            rx_ie    <= 1'b0;
            err_ie   <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_RATE)
                rate_q <= reg_wdata[RATE_W-1:0];
            if (reg_addr == ADDR_CTRL) begin
                trig_sel <= reg_wdata[CT_TRIG_LO +: 3];
                tmo_sel  <= reg_wdata[CT_TMO_LO +: 2];
                rx_ie    <= reg_wdata[CT_RX_IE];
                err_ie   <= reg_wdata[CT_ERR_IE];
            end
        end
    end

    // sticky error status: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_ovr <= 1'b0;
            sts_brk <= 1'b0;
            sts_fe  <= 1'b0;
        end else begin
            if (ovr_set)                           sts_ovr <= 1'b1;
            else if (wr_stat && reg_wdata[ST_OVR]) sts_ovr <= 1'b0;
            if (push && entry.brk)                 sts_brk <= 1'b1;
            else if (wr_stat && reg_wdata[ST_BRK]) sts_brk <= 1'b0;
            if (push && entry.fe)                  sts_fe  <= 1'b1;
            else if (wr_stat && reg_wdata[ST_FE])  sts_fe  <= 1'b0;
        end
    end

    // registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                ADDR_FIFO:
                    reg_rdata <= fifo_empty ? 32'h100
                               : 32'({head.brk, head.fe, 1'b0, head.data});
                ADDR_LEVEL: reg_rdata <= 32'(lvl);
                ADDR_STAT:
                    reg_rdata <= 32'({sts_ovr, sts_brk, sts_fe,
                                      tmo_flag, trig_flag, 1'b0});
                ADDR_CTRL: begin
                    reg_rdata                      <= '0;
                    reg_rdata[CT_TRIG_LO +: 3]     <= trig_sel;
                    reg_rdata[CT_RX_IE]            <= rx_ie;
                    reg_rdata[CT_ERR_IE]           <= err_ie;
                    reg_rdata[CT_TMO_LO +: 2]      <= tmo_sel;
                end
                ADDR_RATE:  reg_rdata <= 32'(rate_q);
                default:    reg_rdata <= '0;
            endcase
        end
    end

    assign irq = (rx_ie && (trig_flag || tmo_flag))
              || (err_ie && (sts_ovr || sts_brk || sts_fe));
endmodule

// File: rtl/hsrx_chk.sv
module hsrx_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] lvl,
    input logic             push,
    input logic             fifo_rd,
    input logic             ovr_set,
    input logic             sts_ovr,
    input logic             wr_stat,
    input logic [31:0]      reg_wdata,
    input logic             rx_ie,
    input logic             err_ie,
    input logic             irq
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl) <= DEPTH); // R6

    AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && lvl == '0 && !push) |=> (lvl == '0)); // R8

    AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_set && !fifo_rd) |=> (int'(lvl) == DEPTH)); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> sts_ovr); // R7

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[5] && !ovr_set) |=> !sts_ovr); // R11

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !err_ie) |-> !irq); // R12
endmodule

bind hsrx_top hsrx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .push(push), .fifo_rd(fifo_rd),
    .ovr_set(ovr_set), .sts_ovr(sts_ovr), .wr_stat(wr_stat),
    .reg_wdata(reg_wdata), .rx_ie(rx_ie), .err_ie(err_ie), .irq(irq)
);

// File: tb/hsrx_top_tb_top.sv
`timescale 1ns/1ps
module hsrx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cur_rate = 255;
    bit done = 0;

    always #2.5 clk = ~clk;

    hsrx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic hold_bits(input int nbits);
        repeat (nbits * (cur_rate + 1) * 14) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic stop);
        rx_in = 1'b0;
        hold_bits(1);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            hold_bits(1);
        end
        rx_in = stop;
        hold_bits(1);
        if (!stop) begin
            rx_in = 1'b1;
            hold_bits(2);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(3'd4, v); chk("R1 rate", v, 32'hFF);
        reg_read(3'd3, v); chk("R1 ctrl", v, 32'h0);
        reg_read(3'd1, v); chk("R1 level", v, 32'h0);
        reg_read(3'd2, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        send_char(8'hA5, 1'b1);
        send_char(8'h3C, 1'b1);
        reg_read(3'd1, v); chk("R6 level two", v, 32'd2);
        reg_read(3'd0, v); chk("R2 first byte", v, 32'h0A5);
        reg_read(3'd0, v); chk("R2 second byte", v, 32'h03C);
    endtask

    task automatic t_empty_read();
        logic [31:0] v;
        reg_read(3'd0, v); chk("R8 empty word", v, 32'h100);
        reg_read(3'd1, v); chk("R8 level after empty read", v, 32'd0);
        send_char(8'h81, 1'b1);
        reg_read(3'd0, v); chk("R8 pointer intact", v, 32'h081);
    endtask

    task automatic t_glitch();
        logic [31:0] v;
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_in = 1'b1;
        hold_bits(12);
        reg_read(3'd1, v); chk("R3 glitch rejected", v, 32'd0);
    endtask

    task automatic t_framing_w1c();
        logic [31:0] v;
        send_char(8'h55, 1'b0);
        reg_read(3'd2, v); chk("R4 framing sticky", v & 32'h38, 32'h08);
        reg_read(3'd0, v); chk("R4 framing tag", v, 32'h255);
        reg_write(3'd2, 32'h06);
        reg_read(3'd2, v); chk("R11 zero-write keeps", v & 32'h38, 32'h08);
        reg_write(3'd2, 32'h08);
        reg_read(3'd2, v); chk("R11 w1c clears", v, 32'h0);
    endtask

    task automatic t_break();
        logic [31:0] v;
        send_char(8'h00, 1'b0);
        reg_read(3'd2, v); chk("R5 break sticky", v & 32'h38, 32'h10);
        reg_read(3'd1, v); chk("R5 single entry", v, 32'd1);
        reg_read(3'd0, v); chk("R5 break tag", v, 32'h400);
        reg_write(3'd2, 32'h10);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        reg_write(3'd3, 32'h1 << 2);
        for (int i = 0; i < 3; i++) send_char(8'h20 + 8'(i), 1'b1);
        reg_read(3'd2, v); chk("R9 below threshold 4", v & 32'h2, 32'h0);
        send_char(8'h23, 1'b1);
        reg_read(3'd2, v); chk("R9 at threshold 4", v & 32'h2, 32'h2);
        chk("R12 irq masked", 32'(irq), 32'h0);
        reg_write(3'd3, (32'h1 << 2) | (32'h1 << 6));
        @(negedge clk);
        chk("R12 irq on trigger", 32'(irq), 32'h1);
        reg_write(3'd3, 32'h2 << 2);
        reg_read(3'd2, v); chk("R9 below threshold 8", v & 32'h2, 32'h0);
        for (int i = 0; i < 4; i++) reg_read(3'd0, v);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        reg_write(3'd3, (32'h1 << 16) | (32'h1 << 6) | (32'h5 << 2));
        send_char(8'h77, 1'b1);
        repeat (1000) @(negedge clk);
        reg_read(3'd2, v); chk("R10 not yet timed out", v & 32'h4, 32'h0);
        repeat (300) @(negedge clk);
        reg_read(3'd2, v); chk("R10 timed out", v & 32'h4, 32'h4);
        chk("R12 irq on timeout", 32'(irq), 32'h1);
        reg_read(3'd0, v);
        reg_read(3'd2, v); chk("R10 pop clears", v & 32'h4, 32'h0);
    endtask

    task automatic t_err_irq();
        logic [31:0] v;
        reg_write(3'd3, 32'h1 << 7);
        send_char(8'h0F, 1'b0);
        chk("R12 irq on framing", 32'(irq), 32'h1);
        reg_write(3'd2, 32'h08);
        @(negedge clk);
        chk("R12 irq after clear", 32'(irq), 32'h0);
        reg_read(3'd0, v);
    endtask

    task automatic t_fill();
        logic [31:0] v;
        int bad;
        reg_write(3'd4, 32'h0);
        cur_rate = 0;
        reg_write(3'd3, 32'h5 << 2);
        for (int i = 0; i < 47; i++) send_char(8'h10 + 8'(i), 1'b1);
        reg_read(3'd2, v); chk("R9 below threshold 48", v & 32'h2, 32'h0);
        send_char(8'h10 + 8'd47, 1'b1);
        reg_read(3'd2, v); chk("R9 at threshold 48", v & 32'h2, 32'h2);
        for (int i = 48; i < 65; i++) send_char(8'h10 + 8'(i), 1'b1);
        reg_read(3'd1, v); chk("R7 level stays full", v, 32'd64);
        reg_read(3'd2, v); chk("R7 overrun sticky", v & 32'h20, 32'h20);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            reg_read(3'd0, v);
            if (v !== 32'(8'h10 + 8'(i))) bad++;
        end
        chk("R6 order of 64 entries", 32'(bad), 32'h0);
        reg_read(3'd0, v); chk("R7 extra byte discarded", v, 32'h100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        reg_write(3'd4, 32'h1);
        cur_rate = 1;
        hold_bits(1);
        t_basic();
        t_empty_read();
        t_glitch();
        t_framing_w1c();
        t_break();
        t_trigger();
        t_timeout();
        t_err_irq();
        t_fill();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule